// File: doc/BRIEF.md
# Per-Lane 18-Bit Single-Error-Correcting Codec

This block adds hidden single-error correction to a 36-bit double-data-rate memory data bus. The bus is treated as four independent 9-bit lanes. On the write side, each lane takes the 9 bits it carries in the first beat and the 9 bits it carries in the second beat, forms an 18-bit word and appends 5 check bits. This gives a 23-bit codeword per lane and 92 stored bits in total. On the read side, each lane recomputes its 5-bit syndrome from the stored 23 bits and repairs any single flipped bit. It then hands back the two 9-bit beats in their original order.

The code is a plain Hamming single-error-correcting code. A lane reports that it made a repair and, separately, that its syndrome pointed outside the codeword. Two or more flipped bits in one lane are neither detected nor reported. Such a word may be silently miscorrected. The memory array and the bus timing sit outside this block. Encoder and decoder are combinational per lane. An optional output register stage is selected by the `OUT_REG` parameter.

Top module: `lane_sec_codec`

## Requirements
- R1: Lane L (0 to 3) uses bits [9L+8:9L] of both beats. Its codeword sits in bits [23L+22:23L] of the 92-bit code buses. Errors in one lane never change the data or flags of another lane.
- R2: Codeword bit p-1 holds Hamming position p (1 to 23). Positions 1, 2, 4, 8 and 16 are check bits. The remaining 18 positions take data in ascending order: beat-0 lane bits 0 to 8 first, then beat-1 lane bits 0 to 8. Each check bit at position 2^k makes the parity even over all positions whose index has bit k set.
- R3: If a received lane word has syndrome 0 (the XOR of the positions of all set bits), its data is returned unchanged and neither of its flags is set.
- R4: If a single data bit in a lane is flipped, the original data is returned and that lane's corrected flag is set.
- R5: If a single check bit in a lane is flipped, the data is returned unchanged and that lane's corrected flag is set.
- R6: If a syndrome lies between 24 and 31, the data is taken uncorrected from the received data positions. The lane's invalid-syndrome flag is set and its corrected flag is clear.
- R7: Two flipped bits in a lane raise no flag beyond what the syndrome gives. A syndrome of 1 to 23 causes a flip of that position and sets the corrected flag, even when that flip is wrong.
- R8: With `OUT_REG`=1, every output shows the result for the inputs of the previous clock edge, and all outputs are zero while reset is held. With `OUT_REG`=0, the outputs are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_beat0 | input | 36 | First write beat |
| wr_beat1 | input | 36 | Second write beat |
| wr_code | output | 92 | Four 23-bit codewords to store |
| rd_code | input | 92 | Four 23-bit codewords read back |
| rd_beat0 | output | 36 | First corrected read beat |
| rd_beat1 | output | 36 | Second corrected read beat |
| rd_fixed | output | 4 | Per-lane corrected flag |
| rd_badsyn | output | 4 | Per-lane invalid-syndrome flag |

## Verification
The write path and the read path work in the same cycle. On every clock, the bench drives fresh random write data together with a read codeword that carries errors. It compares the codeword and the decoded read results one cycle later against a behavioural model. Within a cycle, one lane may be repairing a bit while the others pass clean data or report a bad syndrome. The bench provokes this by injecting each single error in one lane only, and it judges all four lanes' data and flags on each comparison. The model decodes by trying every single-bit flip until the parity checks pass, rather than by reading a syndrome. This gives an independent view of correction, miscorrection on double errors, and invalid syndromes.

// File: rtl/lane_sec_codec.sv
module lane_sec_codec #(
  parameter int LANES   = 4,
  parameter int LANE_W  = 9,
  parameter int OUT_REG = 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [LANES*LANE_W-1:0]      wr_beat0,
  input  logic [LANES*LANE_W-1:0]      wr_beat1,
  output logic [LANES*(2*LANE_W+5)-1:0] wr_code,
  input  logic [LANES*(2*LANE_W+5)-1:0] rd_code,
  output logic [LANES*LANE_W-1:0]      rd_beat0,
  output logic [LANES*LANE_W-1:0]      rd_beat1,
  output logic [LANES-1:0]             rd_fixed,
  output logic [LANES-1:0]             rd_badsyn
);
  localparam int DW  = 2*LANE_W;
  localparam int PW  = 5;
  localparam int CW  = DW + PW;
  localparam int BW  = LANES*LANE_W;
  localparam int TW  = LANES*CW;

  function automatic logic [PW-1:0] synd(input logic [CW-1:0] c);
    logic [PW-1:0] s;
    s = '0;
    for (int p = 1; p <= CW; p++)
      if (c[p-1]) s = s ^ PW'(p);
    return s;
  endfunction

  function automatic logic [CW-1:0] place(input logic [DW-1:0] d);
    logic [CW-1:0] c;
    int j;
    c = '0;
    j = 0;
    for (int p = 1; p <= CW; p++)
      if ((p & (p-1)) != 0) begin
        c[p-1] = d[j];
        j++;
      end
    return c;
  endfunction

  function automatic logic [DW-1:0] pick(input logic [CW-1:0] c);
    logic [DW-1:0] d;
    int j;
    d = '0;
    j = 0;
    for (int p = 1; p <= CW; p++)
      if ((p & (p-1)) != 0) begin
        d[j] = c[p-1];
        j++;
      end
    return d;
  endfunction

  function automatic logic [CW-1:0] encode(input logic [DW-1:0] d);
    logic [CW-1:0] w;
    logic [PW-1:0] s;
    w = place(d);
    s = synd(w);
    for (int k = 0; k < PW; k++) w[(1<<k)-1] = s[k];
    return w;
  endfunction

  logic [TW-1:0]    enc_all;
  logic [BW-1:0]    dec_b0, dec_b1;
  logic [LANES-1:0] fix_all, bad_all;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [DW-1:0] wd, dat, raw;
    logic [CW-1:0] rx, fixw, enc_c;
    logic [PW-1:0] s;
    logic          hit, bad;

    assign wd    = {wr_beat1[l*LANE_W +: LANE_W], wr_beat0[l*LANE_W +: LANE_W]};
    assign enc_c = encode(wd);
    assign rx    = rd_code[l*CW +: CW];
    assign s     = synd(rx);
    assign hit   = (s != '0) && (s <= PW'(CW));
    assign bad   = (s > PW'(CW));
    assign fixw  = hit ? (rx ^ ({{(CW-1){1'b0}}, 1'b1} << (s - 1'b1))) : rx;
    assign dat   = pick(fixw);
    assign raw   = pick(rx);

    assign enc_all[l*CW +: CW]       = enc_c;
    assign dec_b0[l*LANE_W +: LANE_W] = dat[LANE_W-1:0];
    assign dec_b1[l*LANE_W +: LANE_W] = dat[DW-1:LANE_W];
    assign fix_all[l] = hit;
    assign bad_all[l] = bad;

    assert_enc_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
      synd(enc_c) == '0);
    assert_clean_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (s == '0) |-> (!hit && !bad && dat == raw));
    assert_single_fix_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (synd(fixw) == '0 && $countones(fixw ^ rx) == 1));
    assert_badsyn_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bad |-> (!hit && dat == raw));
  end

  if (OUT_REG != 0) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wr_code   <= '0;
        rd_beat0  <= '0;
        rd_beat1  <= '0;
        rd_fixed  <= '0;
        rd_badsyn <= '0;
      end else begin
        wr_code   <= enc_all;
        rd_beat0  <= dec_b0;
        rd_beat1  <= dec_b1;
        rd_fixed  <= fix_all;
        rd_badsyn <= bad_all;
      end
    end

    assert_rst_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (rd_fixed == '0 && rd_badsyn == '0));
  end else begin : g_comb
    assign wr_code   = enc_all;
    assign rd_beat0  = dec_b0;
    assign rd_beat1  = dec_b1;
    assign rd_fixed  = fix_all;
    assign rd_badsyn = bad_all;
  end
endmodule

// File: tb/lane_sec_codec_tb.sv
module lane_sec_codec_tb_top;
  localparam int L = 4, LW = 9, CW = 23;

  logic clk = 0, rst_n = 0;
  logic [35:0] wr_beat0 = '0, wr_beat1 = '0;
  logic [91:0] rd_code = '0;
  logic [91:0] wr_code;
  logic [35:0] rd_beat0, rd_beat1;
  logic [3:0]  rd_fixed, rd_badsyn;

  always #4 clk = ~clk;

  lane_sec_codec #(.LANES(L), .LANE_W(LW), .OUT_REG(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_beat0(wr_beat0), .wr_beat1(wr_beat1),
    .wr_code(wr_code), .rd_code(rd_code), .rd_beat0(rd_beat0),
    .rd_beat1(rd_beat1), .rd_fixed(rd_fixed), .rd_badsyn(rd_badsyn));

  int compared = 0, mismatched = 0;
  logic [91:0] q_code[$];
  logic [35:0] q_b0[$], q_b1[$];
  logic [3:0]  q_fix[$], q_bad[$];
  string       q_tag[$];

  function automatic bit is_chk(int p);
    return p == 1 || p == 2 || p == 4 || p == 8 || p == 16;
  endfunction

  function automatic logic [22:0] m_enc(logic [17:0] d);
    logic [22:0] w;
    int j;
    w = '0;
    j = 0;
    for (int p = 1; p <= 23; p++)
      if (!is_chk(p)) begin w[p-1] = d[j]; j++; end
    for (int k = 0; k < 5; k++) begin
      bit par;
      par = 0;
      for (int p = 1; p <= 23; p++)
        if (!is_chk(p) && ((p >> k) & 1)) par ^= w[p-1];
      w[(1 << k) - 1] = par;
    end
    return w;
  endfunction

  function automatic bit m_ok(logic [22:0] w);
    for (int k = 0; k < 5; k++) begin
      bit par;
      par = 0;
      for (int p = 1; p <= 23; p++)
        if ((p >> k) & 1) par ^= w[p-1];
      if (par) return 0;
    end
    return 1;
  endfunction

  function automatic logic [17:0] m_data(logic [22:0] w);
    logic [17:0] d;
    int j;
    d = '0;
    j = 0;
    for (int p = 1; p <= 23; p++)
      if (!is_chk(p)) begin d[j] = w[p-1]; j++; end
    return d;
  endfunction

  task automatic push(input logic [35:0] b0, input logic [35:0] b1,
                      input logic [91:0] rx, input string tag);
    logic [91:0] ec;
    logic [35:0] e0, e1;
    logic [3:0]  ef, eb;
    for (int l = 0; l < L; l++) begin
      logic [22:0] w, t;
      logic [17:0] d;
      bit found;
      ec[l*CW +: CW] = m_enc({b1[l*LW +: LW], b0[l*LW +: LW]});
      w = rx[l*CW +: CW];
      found = 0;
      ef[l] = 0;
      d = m_data(w);
      for (int c = 0; c <= 23 && !found; c++) begin
        t = w;
        if (c > 0) t[c-1] = ~t[c-1];
        if (m_ok(t)) begin found = 1; d = m_data(t); ef[l] = (c > 0); end
      end
      eb[l] = !found;
      e0[l*LW +: LW] = d[8:0];
      e1[l*LW +: LW] = d[17:9];
    end
    q_code.push_back(ec); q_b0.push_back(e0); q_b1.push_back(e1);
    q_fix.push_back(ef);  q_bad.push_back(eb); q_tag.push_back(tag);
  endtask

  task automatic chk(input string what, input logic [91:0] act, input logic [91:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic compare_front();
    string t;
    t = q_tag.pop_front();
    chk({"R2 R1 wr_code ", t}, wr_code, q_code.pop_front());
    chk({t, " rd_beat0"}, {56'b0, rd_beat0}, {56'b0, q_b0.pop_front()});
    chk({t, " rd_beat1"}, {56'b0, rd_beat1}, {56'b0, q_b1.pop_front()});
    chk({t, " rd_fixed"}, {88'b0, rd_fixed}, {88'b0, q_fix.pop_front()});
    chk({t, " rd_badsyn"}, {88'b0, rd_badsyn}, {88'b0, q_bad.pop_front()});
  endtask

  task automatic step(input logic [35:0] b0, input logic [35:0] b1,
                      input logic [91:0] rx, input string tag);
    @(negedge clk);
    if (q_tag.size() > 0) compare_front();
    wr_beat0 = b0; wr_beat1 = b1; rd_code = rx;
    push(b0, b1, rx, tag);
  endtask

  function automatic logic [91:0] enc_all(logic [35:0] b0, logic [35:0] b1);
    logic [91:0] c;
    for (int l = 0; l < L; l++)
      c[l*CW +: CW] = m_enc({b1[l*LW +: LW], b0[l*LW +: LW]});
    return c;
  endfunction

  function automatic logic [35:0] r36();
    return {$urandom, $urandom};
  endfunction

  initial begin
    #2000000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    wr_beat0 = r36(); wr_beat1 = r36(); rd_code = {$urandom, $urandom, $urandom};
    repeat (3) @(negedge clk);
    // R8: outputs held at zero during reset
    chk("R8 reset wr_code", wr_code, '0);
    chk("R8 reset rd_beat0", {56'b0, rd_beat0}, '0);
    chk("R8 reset flags", {84'b0, rd_fixed, rd_badsyn}, '0);
    rst_n = 1;

    // R3: clean loopback and all-zero / all-one words
    step('0, '0, '0, "R3 zero");
    step('1, '1, enc_all('1, '1), "R3 ones");
    for (int i = 0; i < 40; i++) begin
      logic [35:0] a, b;
      a = r36(); b = r36();
      step(r36(), r36(), enc_all(a, b), "R3 clean");
    end

    // R4 R5 R1: every single-bit error in every lane, other lanes clean
    for (int l = 0; l < L; l++)
      for (int p = 1; p <= 23; p++) begin
        logic [35:0] a, b;
        logic [91:0] c;
        a = r36(); b = r36();
        c = enc_all(a, b);
        c[l*CW + p - 1] = ~c[l*CW + p - 1];
        step(r36(), r36(), c, is_chk(p) ? "R5 R1 check-bit error" : "R4 R1 data-bit error");
      end

    // R4 R1: single errors in all lanes at once
    for (int i = 0; i < 20; i++) begin
      logic [91:0] c;
      c = enc_all(r36(), r36());
      for (int l = 0; l < L; l++) begin
        int p;
        p = 1 + int'($urandom % 23);
        c[l*CW + p - 1] = ~c[l*CW + p - 1];
      end
      step(r36(), r36(), c, "R4 R1 all lanes");
    end

    // R6: syndromes 24..31 built from flips at positions 16, 8 and low bits
    for (int s = 24; s < 32; s++) begin
      logic [91:0] c;
      int l;
      l = int'($urandom % 4);
      c = enc_all(r36(), r36());
      for (int k = 0; k < 5; k++)
        if ((s >> k) & 1) c[l*CW + (1 << k) - 1] = ~c[l*CW + (1 << k) - 1];
      step(r36(), r36(), c, "R6 invalid syndrome");
    end

    // R7: double errors, possible miscorrection
    for (int i = 0; i < 100; i++) begin
      logic [91:0] c;
      int l, p1, p2;
      l = int'($urandom % 4);
      p1 = 1 + int'($urandom % 23);
      p2 = 1 + int'(((p1 - 1) + 1 + ($urandom % 22)) % 23);
      c = enc_all(r36(), r36());
      c[l*CW + p1 - 1] = ~c[l*CW + p1 - 1];
      c[l*CW + p2 - 1] = ~c[l*CW + p2 - 1];
      step(r36(), r36(), c, "R7 double error");
    end

    // R8: drain last pending comparison
    step('0, '0, '0, "R8 drain");
    @(negedge clk);
    compare_front();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule